// File: doc/BRIEF.md
# MMU Control and Fault-Interrupt Register Block

This block is the software-visible control and status front end of a small device-side memory management unit. A host reaches it through 32-bit register reads and writes on a simple request channel. Its settings drive the translation unit through plain pins: MMU enable, table-walk enable, emulator-TLB mode, translation-table base, idle mode and auto-idle. The lookup logic and the page-table walker live elsewhere. They report faults to this block as single-cycle event pulses. Each pulse carries a five-bit source vector and the address that faulted.

Each fault source sets a sticky status bit, which software clears by writing a one to it. A matching enable register masks the status bits into one level-sensitive interrupt line. The first fault that arrives while no enabled status bit is pending has its address captured. That address is held until software has cleared the pending status. A self-clearing soft reset returns every register except the revision to its default after a fixed number of cycles. Software polls a reset-done flag to see when that reset has finished.

The request channel uses valid/ready. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. Reads are always ready. A write is held off (`req_ready` low) for as long as a soft reset is in progress, and the requester must keep the request stable until it is accepted. A read returns `rsp_valid` with its data exactly one cycle after acceptance. The response channel has no back-pressure.

Top module: `mmu_ctl_regs`

## Requirements
- R1: The register at offset 0x00 reads the version, with the major number in bits 7:4 and the minor number in bits 3:0 (default 1.1, read value 0x11). Writes to it have no effect, and no soft reset changes it.
- R2: The system-configuration register at offset 0x10 holds auto-idle in bit 0 and the idle mode in bits 4:3 (0 force, 1 none, 2 smart). Both read back and drive `auto_idle` and `idle_mode`. All other bits read zero, except bit 1 during a soft reset.
- R3: Writing 1 to bit 1 of offset 0x10 starts a soft reset. Bit 1 reads 1 while the reset runs and clears itself. Exactly 4 cycles after the accepting edge, every register except the version returns to zero. Fault events that arrive during the reset are ignored.
- R4: Bit 0 of the status register at offset 0x14 reads 0 while a soft reset is in progress and 1 otherwise. With a reset accepted at edge E0, reads accepted at edges E0+1 through E0+4 return 0 and a read at E0+5 returns 1.
- R5: The interrupt status register at offset 0x18 uses bit 0 for TLB miss, bit 1 for translation fault, bit 2 for emulation miss, bit 3 for table-walk fault and bit 4 for multi-hit fault. A fault event sets each bit given in its source vector. Writing 1 clears a bit, and writing 0 leaves it unchanged. A set and a clear of the same bit on the same edge leave the bit set.
- R6: The interrupt enable register at offset 0x1C holds five enable bits in the same layout as the status register. The upper bits read zero.
- R7: `irq` is high exactly when some status bit and its enable bit are both 1. Status bits stay set while masked.
- R8: A fault event with at least one source bit set stores its address in the fault-address register at offset 0x48, but only if no enabled status bit is set at that moment. Otherwise the stored address is kept.
- R9: The control register at offset 0x44 holds MMU enable in bit 1, table-walk enable in bit 2 and emulator-TLB mode in bit 3. These bits drive `mmu_en`, `walk_en` and `emu_tlb_mode`. The other bits read zero.
- R10: The table-base register at offset 0x4C stores the written value with bits 13:0 forced to zero (16 KiB alignment). It reads back and drives `ttb_addr`.
- R11: A read is always accepted and answers with `rsp_valid` one cycle later. Unmapped offsets (for example 0x40 and 0x54) read zero and ignore writes. During a soft reset, writes are stalled and are accepted on the first edge after it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read is accepted |
| rsp_rdata | output | DATA_W | Read data |
| fault_valid | input | 1 | Fault event pulse from the translation unit |
| fault_src | input | NUM_SRC | Fault sources of this event, in the status bit layout |
| fault_addr | input | DATA_W | Address that caused the fault |
| irq | output | 1 | Level interrupt |
| mmu_en | output | 1 | Translation enable |
| walk_en | output | 1 | Table-walk enable |
| emu_tlb_mode | output | 1 | Emulator-TLB mode select |
| ttb_addr | output | DATA_W | Aligned translation-table base |
| idle_mode | output | 2 | Idle mode field |
| auto_idle | output | 1 | Auto-idle enable |

## Verification
The bound checker runs on every cycle. It checks that a read response follows each accepted read and only accepted reads. It checks that reads are never refused and that no write is accepted during the four cycles of a soft reset. It also checks that status bits rise only after a fault event, that `irq` never rises without a pending status bit, and that the captured fault address does not move while an enabled interrupt is pending. The bench scenarios show what a property cannot easily pin down: the exact poll sequence of the reset-done flag and the full default state afterwards. They also cover the masking of fields and the alignment of the table base, which status bit a set/clear collision leaves behind, and which address is kept when faults arrive in a burst.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  // Register byte offsets
  localparam logic [7:0] OFF_VERSION = 8'h00;
  localparam logic [7:0] OFF_SYSCFG  = 8'h10;
  localparam logic [7:0] OFF_SYSSTAT = 8'h14;
  localparam logic [7:0] OFF_IRQST   = 8'h18;
  localparam logic [7:0] OFF_IRQEN   = 8'h1C;
  localparam logic [7:0] OFF_CTRL    = 8'h44;
  localparam logic [7:0] OFF_FADDR   = 8'h48;
  localparam logic [7:0] OFF_TTB     = 8'h4C;

  // System configuration bit positions
  localparam int SC_AUTOIDLE = 0;
  localparam int SC_SRST     = 1;
  localparam int SC_IDLE_LO  = 3;

  // Control bit positions
  localparam int CT_MMU  = 1;
  localparam int CT_WALK = 2;
  localparam int CT_EMU  = 3;

  typedef enum logic [1:0] {
    IDLE_FORCE = 2'd0,
    IDLE_NONE  = 2'd1,
    IDLE_SMART = 2'd2
  } idle_mode_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_SYSCFG,
    SEL_SYSSTAT,
    SEL_IRQST,
    SEL_IRQEN,
    SEL_CTRL,
    SEL_FADDR,
    SEL_TTB
  } reg_sel_e;

endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFF_VERSION)) sel = SEL_VERSION;
    if (addr == ADDR_W'(OFF_SYSCFG))  sel = SEL_SYSCFG;
    if (addr == ADDR_W'(OFF_SYSSTAT)) sel = SEL_SYSSTAT;
    if (addr == ADDR_W'(OFF_IRQST))   sel = SEL_IRQST;
    if (addr == ADDR_W'(OFF_IRQEN))   sel = SEL_IRQEN;
    if (addr == ADDR_W'(OFF_CTRL))    sel = SEL_CTRL;
    if (addr == ADDR_W'(OFF_FADDR))   sel = SEL_FADDR;
    if (addr == ADDR_W'(OFF_TTB))     sel = SEL_TTB;
  end

endmodule

// File: rtl/mmu_ctl_srst.sv
module mmu_ctl_srst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(RST_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

endmodule

// File: rtl/mmu_ctl_fault.sv
module mmu_ctl_fault #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ev_valid,
  input  logic [NUM_SRC-1:0] ev_src,
  input  logic [DATA_W-1:0]  ev_addr,
  input  logic               en_we,
  input  logic               w1c_we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic [DATA_W-1:0]  fault_addr,
  output logic               irq
);

  logic [NUM_SRC-1:0] st_q;
  logic [NUM_SRC-1:0] en_q;
  logic [DATA_W-1:0]  fa_q;
  logic               pending;

  assign pending = |(st_q & en_q);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // a new event wins over a same-edge clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      st_q[i] <= 1'b0;
      else if (clr)                    st_q[i] <= 1'b0;
      else if (ev_valid && ev_src[i])  st_q[i] <= 1'b1;
      else if (w1c_we && wdata[i])     st_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (clr)   en_q <= '0;
    else if (en_we) en_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    fa_q <= '0;
    else if (clr)                                  fa_q <= '0;
    else if (ev_valid && (|ev_src) && !pending)    fa_q <= ev_addr;
  end

  assign status     = st_q;
  assign enable     = en_q;
  assign fault_addr = fa_q;
  assign irq        = pending;

endmodule

// File: rtl/mmu_ctl_cfg.sv
module mmu_ctl_cfg
  import mmu_ctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ALIGN_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              syscfg_we,
  input  logic              ctrl_we,
  input  logic              ttb_we,
  input  logic [DATA_W-1:0] wdata,
  output idle_mode_e        idle_mode,
  output logic              auto_idle,
  output logic [2:0]        ctrl_bits,
  output logic [DATA_W-1:0] ttb
);

  localparam int HI_W = DATA_W - ALIGN_W;

  logic [1:0]      idle_q;
  logic            aidle_q;
  logic [2:0]      ctrl_q;
  logic [HI_W-1:0] ttb_hi_q;
  logic            unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 2'd0;
      aidle_q <= 1'b0;
    end else if (clr) begin
      idle_q  <= 2'd0;
      aidle_q <= 1'b0;
    end else if (syscfg_we) begin
      idle_q  <= wdata[SC_IDLE_LO+1:SC_IDLE_LO];
      aidle_q <= wdata[SC_AUTOIDLE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (clr)     ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wdata[CT_EMU:CT_MMU];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ttb_hi_q <= '0;
    else if (clr)    ttb_hi_q <= '0;
    else if (ttb_we) ttb_hi_q <= wdata[DATA_W-1:ALIGN_W];
  end

  assign unused_wbits = ^wdata[ALIGN_W-1:SC_IDLE_LO+2];

  assign idle_mode = idle_mode_e'(idle_q);
  assign auto_idle = aidle_q;
  assign ctrl_bits = ctrl_q;
  assign ttb       = {ttb_hi_q, {ALIGN_W{1'b0}}};

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 5,
  parameter int RST_CYCLES = 4,
  parameter int ALIGN_W    = 14,
  parameter int VER_MAJOR  = 1,
  parameter int VER_MINOR  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               fault_valid,
  input  logic [NUM_SRC-1:0] fault_src,
  input  logic [DATA_W-1:0]  fault_addr,
  output logic               irq,
  output logic               mmu_en,
  output logic               walk_en,
  output logic               emu_tlb_mode,
  output logic [DATA_W-1:0]  ttb_addr,
  output logic [1:0]         idle_mode,
  output logic               auto_idle
);

  localparam logic [7:0] VERSION_VAL = {4'(VER_MAJOR), 4'(VER_MINOR)};

  reg_sel_e           sel;
  logic               acc, wr_acc, rd_acc;
  logic               srst_start, srst_busy, srst_done;
  logic [NUM_SRC-1:0] irq_status, irq_enable;
  logic [DATA_W-1:0]  fault_addr_q;
  logic [2:0]         ctrl_bits;
  idle_mode_e         idle_e;
  logic [DATA_W-1:0]  rd_mux;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  // reads always pass; writes wait out a soft reset
  assign req_ready  = !(srst_busy && req_write);
  assign acc        = req_valid && req_ready;
  assign wr_acc     = acc && req_write;
  assign rd_acc     = acc && !req_write;
  assign srst_start = wr_acc && (sel == SEL_SYSCFG) && req_wdata[SC_SRST];

  mmu_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .sel  (sel)
  );

  mmu_ctl_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (srst_start),
    .busy  (srst_busy),
    .done  (srst_done)
  );

  mmu_ctl_fault #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (srst_done),
    .ev_valid   (fault_valid && !srst_busy),
    .ev_src     (fault_src),
    .ev_addr    (fault_addr),
    .en_we      (wr_acc && (sel == SEL_IRQEN)),
    .w1c_we     (wr_acc && (sel == SEL_IRQST)),
    .wdata      (req_wdata[NUM_SRC-1:0]),
    .status     (irq_status),
    .enable     (irq_enable),
    .fault_addr (fault_addr_q),
    .irq        (irq)
  );

  mmu_ctl_cfg #(.DATA_W(DATA_W), .ALIGN_W(ALIGN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_done),
    .syscfg_we (wr_acc && (sel == SEL_SYSCFG)),
    .ctrl_we   (wr_acc && (sel == SEL_CTRL)),
    .ttb_we    (wr_acc && (sel == SEL_TTB)),
    .wdata     (req_wdata),
    .idle_mode (idle_e),
    .auto_idle (auto_idle),
    .ctrl_bits (ctrl_bits),
    .ttb       (ttb_addr)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_VERSION: rd_mux[7:0] = VERSION_VAL;
      SEL_SYSCFG: begin
        rd_mux[SC_IDLE_LO+1:SC_IDLE_LO] = idle_e;
        rd_mux[SC_SRST]                 = srst_busy;
        rd_mux[SC_AUTOIDLE]             = auto_idle;
      end
      SEL_SYSSTAT: rd_mux[0]               = !srst_busy;
      SEL_IRQST:   rd_mux[NUM_SRC-1:0]     = irq_status;
      SEL_IRQEN:   rd_mux[NUM_SRC-1:0]     = irq_enable;
      SEL_CTRL:    rd_mux[CT_EMU:CT_MMU]   = ctrl_bits;
      SEL_FADDR:   rd_mux                  = fault_addr_q;
      SEL_TTB:     rd_mux                  = ttb_addr;
      default:     rd_mux                  = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_rdata_q;
  assign mmu_en       = ctrl_bits[0];
  assign walk_en      = ctrl_bits[1];
  assign emu_tlb_mode = ctrl_bits[2];
  assign idle_mode    = idle_e;

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk #(
  parameter int NUM_SRC    = 5,
  parameter int DATA_W     = 32,
  parameter int RST_CYCLES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               fault_valid,
  input logic               irq,
  input logic               srst_start,
  input logic               srst_busy,
  input logic [NUM_SRC-1:0] irq_status,
  input logic [DATA_W-1:0]  fault_addr_q
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win_q <= '0;
    else if (srst_start) win_q <= CW'(RST_CYCLES);
    else if (win_q != 0) win_q <= win_q - 1'b1;
  end

  // R11: every accepted read is answered on the next cycle
  p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  // R11: no response without an accepted read
  p_rsp_only_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R11: reads are never refused
  p_read_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_ready);

  // R3: no write lands inside the reset window
  p_no_write_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != 0) |-> !(req_valid && req_ready && req_write));

  // R5: status bits rise only after a fault event
  p_status_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |=> ((irq_status & ~$past(irq_status)) == '0));

  // R7: the line is never high without a pending status bit
  p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_status != '0));

  // R8: captured address holds while an enabled bit is pending
  p_faddr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !srst_busy) |=> $stable(fault_addr_q));

endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .fault_valid  (fault_valid),
  .irq          (irq),
  .srst_start   (srst_start),
  .srst_busy    (srst_busy),
  .irq_status   (irq_status),
  .fault_addr_q (fault_addr_q)
);

// File: tb/mmu_ctl_regs_tb.sv
`timescale 1ns/1ps
module mmu_ctl_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        fault_valid = 1'b0;
  logic [4:0]  fault_src = '0;
  logic [31:0] fault_addr = '0;
  logic        irq, mmu_en, walk_en, emu_tlb_mode, auto_idle;
  logic [31:0] ttb_addr;
  logic [1:0]  idle_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mmu_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fault_valid(fault_valid),
    .fault_src(fault_src), .fault_addr(fault_addr), .irq(irq), .mmu_en(mmu_en),
    .walk_en(walk_en), .emu_tlb_mode(emu_tlb_mode), .ttb_addr(ttb_addr),
    .idle_mode(idle_mode), .auto_idle(auto_idle)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output int waits);
    waits = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) begin
      waits++;
      @(posedge clk);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    access(1'b1, a, d, w);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    int w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    access(1'b0, a, 32'h0, w);
  endtask

  task automatic fault(input logic [4:0] src, input logic [31:0] a);
    @(negedge clk);
    fault_valid = 1'b1; fault_src = src; fault_addr = a;
    @(negedge clk);
    fault_valid = 1'b0; fault_src = '0;
  endtask

  // monitor: pop expected read data as responses appear
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected response: actual=%h expected=none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(8'h00, 32'h11, "R1 version at reset");
    rd(8'h10, 32'h0,  "R2 syscfg at reset");
    rd(8'h14, 32'h1,  "R4 reset done after power-up");
    rd(8'h18, 32'h0,  "R5 status at reset");
    rd(8'h1C, 32'h0,  "R6 enable at reset");
    rd(8'h44, 32'h0,  "R9 control at reset");
    rd(8'h48, 32'h0,  "R8 fault addr at reset");
    rd(8'h4C, 32'h0,  "R10 table base at reset");
    @(negedge clk);
    check("R7 irq at reset", {31'b0, irq}, 32'h0);

    // R1 read-only version
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h11, "R1 version after write");

    // R9 control bits
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, 32'h0000_000E, "R9 control masked");
    @(negedge clk);
    check("R9 pins all set", {29'b0, emu_tlb_mode, walk_en, mmu_en}, 32'h7);
    wr(8'h44, 32'h0000_0006);
    rd(8'h44, 32'h6, "R9 control 6");
    @(negedge clk);
    check("R9 pins mmu+walk", {29'b0, emu_tlb_mode, walk_en, mmu_en}, 32'h3);

    // R10 alignment
    wr(8'h4C, 32'h1234_5FFF);
    rd(8'h4C, 32'h1234_4000, "R10 table base aligned");
    @(negedge clk);
    check("R10 ttb_addr pin", ttb_addr, 32'h1234_4000);

    // R2 system configuration
    wr(8'h10, 32'hFFFF_FFF9);
    rd(8'h10, 32'h19, "R2 syscfg all fields");
    wr(8'h10, 32'h11);
    rd(8'h10, 32'h11, "R2 syscfg smart+autoidle");
    @(negedge clk);
    check("R2 idle/autoidle pins", {29'b0, idle_mode, auto_idle}, 32'h5);

    // R11 unmapped offsets
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, 32'h0, "R11 unmapped 0x54");
    rd(8'h40, 32'h0, "R11 unmapped 0x40");

    // R6 enable, R5/R7/R8 faults
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h1F, "R6 enable masked");
    fault(5'h02, 32'hA000_1000);
    check("R7 irq after fault", {31'b0, irq}, 32'h1);
    rd(8'h18, 32'h02, "R5 translation fault bit");
    rd(8'h48, 32'hA000_1000, "R8 first address captured");
    fault(5'h08, 32'hB000_2000);
    rd(8'h18, 32'h0A, "R5 second source accumulates");
    rd(8'h48, 32'hA000_1000, "R8 address held while pending");
    wr(8'h18, 32'h02);
    rd(8'h18, 32'h08, "R5 write-one clears one bit");
    @(negedge clk);
    check("R7 irq still pending", {31'b0, irq}, 32'h1);
    rd(8'h48, 32'hA000_1000, "R8 address held after partial clear");
    wr(8'h18, 32'h08);
    @(negedge clk);
    check("R7 irq after full clear", {31'b0, irq}, 32'h0);
    rd(8'h18, 32'h0, "R5 status empty");

    // R5 set wins over same-edge clear
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h18; req_wdata = 32'h10;
    fault_valid = 1'b1; fault_src = 5'h10; fault_addr = 32'hE000_0000;
    @(posedge clk);
    #1 req_valid = 1'b0; fault_valid = 1'b0; fault_src = '0;
    rd(8'h18, 32'h10, "R5 set beats clear");
    rd(8'h48, 32'hE000_0000, "R8 captured on collision");
    wr(8'h18, 32'h1F);

    // R7 masking, R8 capture while masked
    wr(8'h1C, 32'h0);
    fault(5'h01, 32'hC000_3000);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h18, 32'h01, "R7 masked status kept");
    rd(8'h48, 32'hC000_3000, "R8 captured while masked");
    wr(8'h1C, 32'h01);
    @(negedge clk);
    check("R7 irq on enable", {31'b0, irq}, 32'h1);
    fault(5'h04, 32'hD000_4000);
    rd(8'h18, 32'h05, "R5 emulation miss added");
    rd(8'h48, 32'hC000_3000, "R8 later fault not captured");
    wr(8'h18, 32'h1F);
    wr(8'h1C, 32'h1F);
    fault(5'h08, 32'h0F00_0000);

    // R3/R4 soft reset with polling; faults during reset ignored
    wr(8'h10, 32'h2);
    fault_valid = 1'b1; fault_src = 5'h1F; fault_addr = 32'h5555_0000;
    rd(8'h14, 32'h0, "R4 busy poll 1");
    rd(8'h10, 32'h2, "R3 reset bit reads set");
    fault_valid = 1'b0; fault_src = '0;
    rd(8'h14, 32'h0, "R4 busy poll 3");
    rd(8'h14, 32'h0, "R4 busy poll 4");
    rd(8'h14, 32'h1, "R4 done on fifth poll");
    rd(8'h00, 32'h11, "R1 version survives soft reset");
    rd(8'h10, 32'h0,  "R3 syscfg default, bit self-cleared");
    rd(8'h18, 32'h0,  "R3 status cleared, faults ignored");
    rd(8'h1C, 32'h0,  "R3 enable default");
    rd(8'h44, 32'h0,  "R3 control default");
    rd(8'h48, 32'h0,  "R3 fault addr default");
    rd(8'h4C, 32'h0,  "R3 table base default");
    @(negedge clk);
    check("R3 pins default", {irq, mmu_en, walk_en, emu_tlb_mode, auto_idle, idle_mode, ttb_addr[24:0]}, 32'h0);

    // R11 write stall during soft reset
    wr(8'h10, 32'h2);
    access(1'b1, 8'h44, 32'h2, w);
    check("R11 write stalled for reset cycles", w, 32'd4);
    rd(8'h44, 32'h2, "R11 stalled write lands after reset");

    repeat (4) @(negedge clk);
    check("R11 all responses seen", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule